// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block is the status and control word of a floating-point unit. It is a 32-bit register with a simple read/write port. The word holds four comparison condition bits, five mode bits and six sticky exception flags. The mode bits select alternative half precision, default-NaN substitution, flush-to-zero and a 2-bit rounding mode. The arithmetic datapath drives a one-cycle pulse per exception and a result strobe for comparisons. The register accumulates those pulses until software clears them with a write.

A second register stores the default mode settings. When the datapath signals the start of a new context, those settings are copied into the live mode field. A single interrupt line is driven from the flags. The inexact flag is deliberately excluded from it, because inexact results are far too frequent to interrupt on, so software has to poll for it.

Top module: `fp_status_ctrl`

## Requirements
- R1: On reset, both the live mode field and the default register take the value of parameter `MODE_RST`, where bit 4 is alternative-half, bit 3 is default-NaN, bit 2 is flush-to-zero and bits 1..0 are the rounding mode. The condition bits, the flags and `irq` are all zero.
- R2: The status word has the following layout:
  - condition bits N, Z, C and V in bits 31..28;
  - alternative-half in bit 26, default-NaN in bit 25, flush-to-zero in bit 24 and the rounding mode in bits 23..22;
  - the input-denormal flag in bit 7;
  - the inexact, underflow, overflow, divide-by-zero and invalid flags in bits 4..0, in that order from bit 4 down.
- R3: Bits 27, 21..8 and 6..5 of the status word always read as zero, whatever is written to them.
- R4: A flag that is set stays set across any number of later cycles and pulses. Only a register write can clear it.
- R5: `exc_pulse` bits are ORed into the flags on the next clock edge. Bit 5 is input-denormal, bit 4 inexact, bit 3 underflow, bit 2 overflow, bit 1 divide-by-zero and bit 0 invalid.
- R6: `irq` is high exactly when, one cycle earlier, any of the input-denormal, underflow, overflow, divide-by-zero or invalid flags was set. No per-flag mask exists.
- R7: The inexact flag alone never raises `irq`. It is still visible in bit 4 of the status word.
- R8: When a register write and a flag pulse occur in the same cycle, each flag becomes the written bit ORed with the pulse bit.
- R9: The condition bits change only on a cycle with `cmp_valid` high, which loads `cmp_nzcv` (bit 3 is N, bit 0 is V), or on a register write. If both occur in the same cycle, the comparison result wins.
- R10: A `dflt_wr_en` write updates only the default register, whose mode bits sit at the same positions as in the status word; its other bits read as zero. `ctx_start` copies the default register into the live mode field and leaves the flags and condition bits unchanged. A status-word write in the same cycle as `ctx_start` takes precedence for the mode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the status word |
| reg_wr_data | input | 32 | Data written to the status word |
| reg_rd_data | output | 32 | Current status word |
| cmp_valid | input | 1 | Comparison result strobe |
| cmp_nzcv | input | 4 | Comparison condition result, N in bit 3 |
| exc_pulse | input | 6 | Per-operation exception pulses |
| dflt_wr_en | input | 1 | Write strobe for the default mode register |
| dflt_wr_data | input | 32 | Data written to the default mode register |
| dflt_rd_data | output | 32 | Current default mode register |
| ctx_start | input | 1 | Load the default modes into the live mode field |
| irq | output | 1 | Registered exception interrupt |

## Verification
The bench builds the block with `MODE_RST` set to 5'b10110, a non-zero value. This makes the reset load of both mode fields observable and tells it apart from an all-zero reset. The bench then checks a context start that reloads different defaults. It also walks every interrupt-capable flag on its own, to measure the one-cycle interrupt lag and the exclusion of the inexact flag. Same-cycle collisions are exercised for three cases: write with pulse, write with comparison, and write with context start.

// File: rtl/fpsc_pkg.sv
package fpsc_pkg;
  localparam int REG_W      = 32;
  localparam int COND_W     = 4;
  localparam int COND_LSB   = 28;
  localparam int MODE_W     = 5;
  localparam int MODE_LSB   = 22;
  localparam int FLAG_W     = 6;
  localparam int LOW_FLAG_W = 5;
  localparam int DENORM_POS = 7;
  localparam int DENORM_IDX = FLAG_W - 1;
  localparam int INEXACT_IDX = 4;

  // flags able to raise the interrupt: everything except inexact
  localparam logic [FLAG_W-1:0] IRQ_MASK = ~(FLAG_W'(1) << INEXACT_IDX);

  localparam logic [REG_W-1:0] COND_FIELD = {{(REG_W-COND_W){1'b0}}, {COND_W{1'b1}}} << COND_LSB;
  localparam logic [REG_W-1:0] MODE_FIELD = {{(REG_W-MODE_W){1'b0}}, {MODE_W{1'b1}}} << MODE_LSB;
  localparam logic [REG_W-1:0] FLAG_FIELD = ({{(REG_W-LOW_FLAG_W){1'b0}}, {LOW_FLAG_W{1'b1}}})
                                            | (REG_W'(1) << DENORM_POS);
  localparam logic [REG_W-1:0] LIVE_BITS  = COND_FIELD | MODE_FIELD | FLAG_FIELD;

  function automatic logic [REG_W-1:0] place_cond(input logic [COND_W-1:0] c);
    return REG_W'(c) << COND_LSB;
  endfunction

  function automatic logic [COND_W-1:0] take_cond(input logic [REG_W-1:0] w);
    return w[COND_LSB +: COND_W];
  endfunction

  function automatic logic [REG_W-1:0] place_mode(input logic [MODE_W-1:0] m);
    return REG_W'(m) << MODE_LSB;
  endfunction

  function automatic logic [MODE_W-1:0] take_mode(input logic [REG_W-1:0] w);
    return w[MODE_LSB +: MODE_W];
  endfunction

  function automatic logic [REG_W-1:0] place_flags(input logic [FLAG_W-1:0] f);
    logic [REG_W-1:0] r;
    r = REG_W'(f[LOW_FLAG_W-1:0]);
    r[DENORM_POS] = f[DENORM_IDX];
    return r;
  endfunction

  function automatic logic [FLAG_W-1:0] take_flags(input logic [REG_W-1:0] w);
    return {w[DENORM_POS], w[LOW_FLAG_W-1:0]};
  endfunction

  function automatic logic wants_irq(input logic [FLAG_W-1:0] f);
    return |(f & IRQ_MASK);
  endfunction
endpackage

// File: rtl/fpsc_cond_bank.sv
module fpsc_cond_bank
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [COND_W-1:0] wr_cond,
  input  logic              cmp_valid,
  input  logic [COND_W-1:0] cmp_cond,
  output logic [COND_W-1:0] cond_q,
  output logic              cond_load
);
  logic [COND_W-1:0] cond_d;

  assign cond_load = cmp_valid | wr_en;

  always_comb begin
    cond_d = cond_q;
    if (wr_en)     cond_d = wr_cond;
    if (cmp_valid) cond_d = cmp_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= '0;
    else        cond_q <= cond_d;
  end

  // R9
  cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_load |=> $stable(cond_q));

  // R9
  cmp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> cond_q == $past(cmp_cond));
endmodule

// File: rtl/fpsc_mode_bank.sv
module fpsc_mode_bank
  import fpsc_pkg::*;
#(
  parameter logic [MODE_W-1:0] MODE_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              dflt_wr_en,
  input  logic [MODE_W-1:0] dflt_wr_mode,
  input  logic              ctx_start,
  output logic [MODE_W-1:0] mode_q,
  output logic [MODE_W-1:0] dflt_q
);
  logic [MODE_W-1:0] mode_d;
  logic              ctx_load;

  assign ctx_load = ctx_start & ~wr_en;

  always_comb begin
    mode_d = mode_q;
    if (ctx_start) mode_d = dflt_q;
    if (wr_en)     mode_d = wr_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      dflt_q <= MODE_RST;
    end else begin
      mode_q <= mode_d;
      if (dflt_wr_en) dflt_q <= dflt_wr_mode;
    end
  end

  // R10
  ctx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_load |=> mode_q == $past(dflt_q));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_start && !wr_en) |=> $stable(mode_q));
endmodule

// File: rtl/fpsc_flag_bank.sv
module fpsc_flag_bank
  import fpsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_flags,
  input  logic [FLAG_W-1:0] pulse,
  output logic [FLAG_W-1:0] flags_q,
  output logic              irq_q
);
  logic [FLAG_W-1:0] flags_d;

  for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_flag
    always_comb flags_d[gi] = (wr_en ? wr_flags[gi] : flags_q[gi]) | pulse[gi];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[gi] <= 1'b0;
      else        flags_q[gi] <= flags_d[gi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= wants_irq(flags_q);
  end

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (flags_q & $past(flags_q)) == $past(flags_q));

  // R5
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |=> (flags_q & $past(pulse)) == $past(pulse));

  // R7
  inexact_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & IRQ_MASK) == '0) |=> !irq_q);
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fpsc_pkg::*;
#(
  parameter logic [MODE_W-1:0] MODE_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  output logic [REG_W-1:0]  reg_rd_data,
  input  logic              cmp_valid,
  input  logic [COND_W-1:0] cmp_nzcv,
  input  logic [FLAG_W-1:0] exc_pulse,
  input  logic              dflt_wr_en,
  input  logic [REG_W-1:0]  dflt_wr_data,
  output logic [REG_W-1:0]  dflt_rd_data,
  input  logic              ctx_start,
  output logic              irq
);
  logic [COND_W-1:0] cond_q;
  logic              cond_load;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] dflt_q;
  logic [FLAG_W-1:0] flags_q;

  fpsc_cond_bank u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_cond   (take_cond(reg_wr_data)),
    .cmp_valid (cmp_valid),
    .cmp_cond  (cmp_nzcv),
    .cond_q    (cond_q),
    .cond_load (cond_load)
  );

  fpsc_mode_bank #(.MODE_RST(MODE_RST)) u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (reg_wr_en),
    .wr_mode      (take_mode(reg_wr_data)),
    .dflt_wr_en   (dflt_wr_en),
    .dflt_wr_mode (take_mode(dflt_wr_data)),
    .ctx_start    (ctx_start),
    .mode_q       (mode_q),
    .dflt_q       (dflt_q)
  );

  fpsc_flag_bank u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_flags (take_flags(reg_wr_data)),
    .pulse    (exc_pulse),
    .flags_q  (flags_q),
    .irq_q    (irq)
  );

  assign reg_rd_data  = place_cond(cond_q) | place_mode(mode_q) | place_flags(flags_q);
  assign dflt_rd_data = place_mode(dflt_q);

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data & ~LIVE_BITS) == '0);

  // R8
  write_or_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> take_flags(reg_rd_data) == ($past(take_flags(reg_wr_data)) | $past(exc_pulse)));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wants_irq(take_flags(reg_rd_data))));
endmodule

// File: tb/fp_status_ctrl_tb_top.sv
module fp_status_ctrl_tb_top;
  localparam logic [4:0] RST_MODES = 5'b10110;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        cmp_valid = 1'b0;
  logic [3:0]  cmp_nzcv = '0;
  logic [5:0]  exc_pulse = '0;
  logic        dflt_wr_en = 1'b0;
  logic [31:0] dflt_wr_data = '0;
  logic [31:0] dflt_rd_data;
  logic        ctx_start = 1'b0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fp_status_ctrl #(.MODE_RST(RST_MODES)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .cmp_valid(cmp_valid), .cmp_nzcv(cmp_nzcv),
    .exc_pulse(exc_pulse), .dflt_wr_en(dflt_wr_en), .dflt_wr_data(dflt_wr_data),
    .dflt_rd_data(dflt_rd_data), .ctx_start(ctx_start), .irq(irq)
  );

  // expected layout, written from the requirement text
  function automatic logic [31:0] word(input logic [3:0] c, input logic [4:0] m,
                                       input logic [5:0] f);
    logic [31:0] w = '0;
    w[31:28] = c;
    w[26:22] = m;
    w[7]     = f[5];
    w[4:0]   = f[4:0];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    reg_wr_en = 0; cmp_valid = 0; exc_pulse = '0; dflt_wr_en = 0; ctx_start = 0;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr_en = 1; reg_wr_data = d;
    step();
  endtask

  task automatic t_reset();
    check("R1 status word", reg_rd_data, word(4'h0, RST_MODES, 6'h00));
    check("R1 default reg", dflt_rd_data, word(4'h0, RST_MODES, 6'h00));
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    check("R2/R3 all-ones write", reg_rd_data, 32'hF7C0_009F);
    check("R6 irq lags write", {31'b0, irq}, 32'h0);
    step();
    check("R6 irq after flags", {31'b0, irq}, 32'h1);
    wr(32'h0);
    check("R4 write clears", reg_rd_data, 32'h0);
    check("R6 irq one more cycle", {31'b0, irq}, 32'h1);
    step();
    check("R6 irq drops", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sticky();
    exc_pulse = 6'b000001; step();
    repeat (5) step();
    check("R4 invalid stays", reg_rd_data, word(4'h0, 5'h0, 6'b000001));
    exc_pulse = 6'b100100; step();
    check("R5 accumulate", reg_rd_data, word(4'h0, 5'h0, 6'b100101));
    wr(32'h0);
    step();
  endtask

  task automatic t_irq_sources();
    for (int b = 0; b < 6; b++) begin
      logic expi;
      expi = (b != 4);
      exc_pulse = 6'(1) << b; step();
      check("R5 single pulse", reg_rd_data, word(4'h0, 5'h0, 6'(1) << b));
      check("R6 no irq yet", {31'b0, irq}, 32'h0);
      repeat (3) step();
      if (expi) check("R6 irq from flag", {31'b0, irq}, 32'h1);
      else      check("R7 inexact no irq", {31'b0, irq}, 32'h0);
      wr(32'h0);
      step();
    end
  endtask

  task automatic t_collision();
    reg_wr_en = 1; reg_wr_data = 32'h0000_0004; exc_pulse = 6'b000010;
    step();
    check("R8 write|pulse", reg_rd_data, word(4'h0, 5'h0, 6'b000110));
    reg_wr_en = 1; reg_wr_data = 32'h0; exc_pulse = 6'b001000;
    step();
    check("R8 pulse beats clear", reg_rd_data, word(4'h0, 5'h0, 6'b001000));
    wr(32'h0);
  endtask

  task automatic t_compare();
    cmp_valid = 1; cmp_nzcv = 4'b1010; step();
    check("R9 cmp loads", reg_rd_data, 32'hA000_0000);
    cmp_nzcv = 4'b0101; exc_pulse = 6'b010000; step();
    check("R9 no strobe holds", reg_rd_data, 32'hA000_0010);
    reg_wr_en = 1; reg_wr_data = 32'h3000_0000; cmp_valid = 1; cmp_nzcv = 4'b0110;
    step();
    check("R9 cmp beats write", reg_rd_data, 32'h6000_0000);
    wr(32'h0);
  endtask

  task automatic t_context();
    dflt_wr_en = 1; dflt_wr_data = 32'hF2C0_00FF; step();
    check("R10 default write", dflt_rd_data, 32'h02C0_0000);
    check("R10 live untouched", reg_rd_data, 32'h0);
    cmp_valid = 1; cmp_nzcv = 4'b0101; exc_pulse = 6'b100000; step();
    ctx_start = 1; step();
    check("R10 ctx load", reg_rd_data, 32'h52C0_0080);
    ctx_start = 1; reg_wr_en = 1; reg_wr_data = 32'h0100_0000; step();
    check("R10 write beats ctx", reg_rd_data, 32'h0100_0000);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_layout();
    t_sticky();
    t_irq_sources();
    t_collision();
    t_compare();
    t_context();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule